// File: doc/BRIEF.md
# Calendar clock register block

This block is the software-visible face of a real-time clock. It sits on a plain 32-bit register bus with an address, a write strobe, a read strobe, write data and read data. It holds a packed calendar date word, a packed time-of-day word, an oscillator control word, scratch words and alarm and configuration words. Apart from the control word, the date word and the time word, every word is plain storage with no side effect. The parameter `MAP_SEL` picks one of two address layouts. The compact layout fills 64 bytes. The wide layout spreads over 512 bytes and adds more scratch and configuration words.

Firmware that sets the clock writes the date word or the time word. Each of those writes raises its own sticky pending bit in the control word. Firmware then polls the control word to see whether the update has been taken. Each read of the control word returns the pending bits and then clears them. A one-cycle `sec_tick` pulse moves the stored time forward by one second. Seconds carry into minutes, minutes into hours, and hours into the weekday and the day of the month. The day rolls into the next month using a month-length rule that knows leap years, and December rolls into the next year.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset every stored word reads as 0 and `bus_rdata` is 0.
- R2: With `MAP_SEL`=0, the control word is at byte offset 0x00, the date word at 0x04 and the time word at 0x08. Plain words sit at 0x0C–0x2C and at 0x3C. With `MAP_SEL`=1, the control word is at 0x00, the date word at 0x10 and the time word at 0x14. Plain words sit at 0x04, 0x08, 0x20–0x30, 0x40–0x50, 0x60, 0x100–0x11C, 0x170, 0x180, 0x190 and 0x1F0.
- R3: A bus write to the date word sets control bit 7, and a bus write to the time word sets control bit 8. A bus write to the control word stores every bit except bits 7 and 8, which the write leaves unchanged.
- R4: A read of the control word returns its value including bits 7 and 8, and clears those two bits. The next read returns them as 0 unless a new date or time write has happened in between.
- R5: Only aligned word accesses are decoded. A read of an offset that is unmapped, beyond the layout or not a multiple of 4 returns 0. A write to such an offset changes no stored word.
- R6: Every plain word, including scratch words 4–7 of the wide layout, returns the last value written to it in full.
- R7: `bus_rdata` is registered. It shows the addressed word in the cycle after the read strobe and holds that value until the next read.
- R8: A `sec_tick` pulse adds one second to the time word. Seconds 59 wrap to 0 and carry into the minute, and minutes 59 wrap to 0 and carry into the hour.
- R9: When the time is 23:59:59, a tick wraps the hour to 0 and advances the weekday. The weekday is held in bits 31:29, 0 stands for Monday and 6 for Sunday, and 6 wraps to 0. The same tick advances the day of the month.
- R10: The date word holds the year offset from `BASE_YEAR` in bits 31:16, the month (1–12) in bits 15:8 and the day in bits 7:0. A day past the month's length returns the day to 1 and advances the month. February has 29 days when `BASE_YEAR`+offset is divisible by 400, or divisible by 4 but not by 100, and 28 days otherwise. Months 4, 6, 9 and 11 have 30 days and the rest have 31. Month 12 wraps to 1 and increments the year offset.
- R11: When a bus write to the date word or the time word lands in the same cycle as a tick, that word takes the written value. The word that is not written still advances from the tick.
- R12: The time word holds the hour in bits 20:16, the minute in bits 13:8 and the second in bits 5:0. A tick leaves all other bits of the time word and the date word as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sec_tick | input | 1 | One-cycle pulse that advances the clock by one second |

## Verification
The assertions assume that the stored calendar fields are in range when a tick arrives: seconds and minutes at most 59, hours at most 23, a month from 1 to 12 and a day within that month. The increment and wrap checks rely on this. The stimulus only writes date and time values that are legal in this sense before it applies ticks. The address sweep writes arbitrary patterns into the date and time words, but it applies no tick until legal values have been written again. The assertions also assume a single bus address per cycle, so a clearing read and a setting write never target different words in the same cycle. The bench keeps to this because it drives one access at a time.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int SLOT_W = 5;
  localparam int PEND_DATE_BIT = 7;
  localparam int PEND_TIME_BIT = 8;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_DATE = 1;
  localparam int SLOT_TIME = 2;
  localparam int FIRST_PLAIN = 3;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } map_hit_t;

  function automatic int slot_count(input bit wide_map);
    return wide_map ? 28 : 13;
  endfunction

  // aligned word index -> storage slot for the selected layout
  function automatic map_hit_t lookup_slot(input bit wide_map, input logic [9:0] w);
    map_hit_t r;
    r = '0;
    if (!wide_map) begin
      if (w <= 10'd11) begin
        r.hit = 1'b1; r.slot = SLOT_W'(w);
      end else if (w == 10'd15) begin
        r.hit = 1'b1; r.slot = 5'd12;
      end
    end else begin
      r.hit = 1'b1;
      if (w == 10'd0)                      r.slot = 5'd0;
      else if (w == 10'd4)                 r.slot = 5'd1;
      else if (w == 10'd5)                 r.slot = 5'd2;
      else if (w == 10'd1)                 r.slot = 5'd3;
      else if (w == 10'd2)                 r.slot = 5'd4;
      else if (w >= 10'd8 && w <= 10'd12)  r.slot = SLOT_W'(w - 10'd8) + 5'd5;
      else if (w >= 10'd16 && w <= 10'd20) r.slot = SLOT_W'(w - 10'd16) + 5'd10;
      else if (w == 10'd24)                r.slot = 5'd15;
      else if (w >= 10'd64 && w <= 10'd71) r.slot = SLOT_W'(w - 10'd64) + 5'd16;
      else if (w == 10'd92)                r.slot = 5'd24;
      else if (w == 10'd96)                r.slot = 5'd25;
      else if (w == 10'd100)               r.slot = 5'd26;
      else if (w == 10'd124)               r.slot = 5'd27;
      else                                 r.hit = 1'b0;
    end
    return r;
  endfunction

  function automatic bit is_leap(input int year);
    if (year % 400 == 0) return 1'b1;
    if (year % 100 == 0) return 1'b0;
    return (year % 4 == 0);
  endfunction

  function automatic logic [7:0] days_in_month(input logic [7:0] mon, input bit leap);
    case (mon)
      8'd2:                         return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:      return 8'd30;
      default:                      return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_map_decode.sv
module rtc_map_decode
  import rtc_cal_pkg::*;
#(
  parameter bit MAP_SEL = 1'b1,
  parameter int AW      = 10
) (
  input  logic [AW-1:0]     addr,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);
  localparam int OFF_W = 12;

  logic [OFF_W-1:0] off;
  map_hit_t         found;

  always_comb begin
    off   = OFF_W'(addr);
    found = lookup_slot(MAP_SEL, off[11:2]);
    hit   = found.hit && (off[1:0] == 2'b00);
    slot  = found.slot;
  end
endmodule

// File: rtl/rtc_clock_step.sv
module rtc_clock_step
  import rtc_cal_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic [31:0] cur_time,
  input  logic [31:0] cur_date,
  output logic [31:0] nxt_time,
  output logic [31:0] nxt_date,
  output logic        evt_sec_wrap,
  output logic        evt_midnight
);
  logic [5:0]  sec, mn;
  logic [4:0]  hr;
  logic [2:0]  dow;
  logic [7:0]  day, mon, mlen;
  logic [15:0] yr;
  logic        min_wrap, day_wrap, mon_wrap;

  always_comb begin
    sec = cur_time[5:0];
    mn  = cur_time[13:8];
    hr  = cur_time[20:16];
    dow = cur_time[31:29];
    day = cur_date[7:0];
    mon = cur_date[15:8];
    yr  = cur_date[31:16];

    evt_sec_wrap = (sec >= 6'd59);
    min_wrap     = evt_sec_wrap && (mn >= 6'd59);
    evt_midnight = min_wrap && (hr >= 5'd23);

    nxt_time = cur_time;
    nxt_time[5:0]   = evt_sec_wrap ? 6'd0 : sec + 6'd1;
    nxt_time[13:8]  = min_wrap ? 6'd0 : (evt_sec_wrap ? mn + 6'd1 : mn);
    nxt_time[20:16] = evt_midnight ? 5'd0 : (min_wrap ? hr + 5'd1 : hr);
    nxt_time[31:29] = evt_midnight ? ((dow >= 3'd6) ? 3'd0 : dow + 3'd1) : dow;

    mlen     = days_in_month(mon, is_leap(BASE_YEAR + int'(yr)));
    day_wrap = evt_midnight && (day >= mlen);
    mon_wrap = day_wrap && (mon >= 8'd12);

    nxt_date = cur_date;
    nxt_date[7:0]   = day_wrap ? 8'd1 : (evt_midnight ? day + 8'd1 : day);
    nxt_date[15:8]  = mon_wrap ? 8'd1 : (day_wrap ? mon + 8'd1 : mon);
    nxt_date[31:16] = mon_wrap ? yr + 16'd1 : yr;
  end
endmodule

// File: rtl/rtc_plain_bank.sv
module rtc_plain_bank
  import rtc_cal_pkg::*;
#(
  parameter int NSLOT = 28,
  parameter int FIRST = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  logic [31:0]            wr_data,
  output logic [NSLOT-1:0][31:0] store_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (wr_en && (int'(wr_slot) >= FIRST) && (int'(wr_slot) < NSLOT)) begin
      store_q[wr_slot] <= wr_data;
    end
  end

  for (genvar g = FIRST; g < NSLOT; g++) begin : g_slot_chk
    // R6: a write lands in its slot in full
    a_r6_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_slot) == g) |=> (store_q[g] == $past(wr_data)));
    // R5: without a write to this slot the slot keeps its value
    a_r5_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && int'(wr_slot) == g) |=> $stable(store_q[g]));
  end
endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
  import rtc_cal_pkg::*;
#(
  parameter bit MAP_SEL   = 1'b1,
  parameter int AW        = 10,
  parameter int BASE_YEAR = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          sec_tick
);
  localparam int          NSLOT     = slot_count(MAP_SEL);
  localparam logic [31:0] PEND_MASK = (32'd1 << PEND_DATE_BIT) | (32'd1 << PEND_TIME_BIT);

  logic              hit;
  logic [SLOT_W-1:0] slot;
  logic [31:0]       ctrl_q, date_q, time_q, ctrl_d;
  logic [31:0]       nxt_time, nxt_date, rd_word;
  logic [NSLOT-1:0][31:0] bank_q;
  logic evt_wr_ctrl, evt_wr_date, evt_wr_time, evt_rd_ctrl, evt_sec_wrap, evt_midnight;

  rtc_map_decode #(.MAP_SEL(MAP_SEL), .AW(AW)) u_dec (
    .addr(bus_addr), .hit(hit), .slot(slot));

  rtc_clock_step #(.BASE_YEAR(BASE_YEAR)) u_step (
    .cur_time(time_q), .cur_date(date_q), .nxt_time(nxt_time), .nxt_date(nxt_date),
    .evt_sec_wrap(evt_sec_wrap), .evt_midnight(evt_midnight));

  rtc_plain_bank #(.NSLOT(NSLOT), .FIRST(FIRST_PLAIN)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit), .wr_slot(slot),
    .wr_data(bus_wdata), .store_q(bank_q));

  always_comb begin
    evt_wr_ctrl = bus_wr && hit && (int'(slot) == SLOT_CTRL);
    evt_wr_date = bus_wr && hit && (int'(slot) == SLOT_DATE);
    evt_wr_time = bus_wr && hit && (int'(slot) == SLOT_TIME);
    evt_rd_ctrl = bus_rd && hit && (int'(slot) == SLOT_CTRL);
  end

  // control word: writable bits from the bus, pending bits set by writes, cleared by reads
  always_comb begin
    ctrl_d = evt_wr_ctrl ? ((bus_wdata & ~PEND_MASK) | (ctrl_q & PEND_MASK)) : ctrl_q;
    ctrl_d[PEND_DATE_BIT] = evt_wr_date || (ctrl_q[PEND_DATE_BIT] && !evt_rd_ctrl);
    ctrl_d[PEND_TIME_BIT] = evt_wr_time || (ctrl_q[PEND_TIME_BIT] && !evt_rd_ctrl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      date_q <= '0;
      time_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (evt_wr_date)   date_q <= bus_wdata;
      else if (sec_tick) date_q <= nxt_date;
      if (evt_wr_time)   time_q <= bus_wdata;
      else if (sec_tick) time_q <= nxt_time;
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit) begin
      case (int'(slot))
        SLOT_CTRL: rd_word = ctrl_q;
        SLOT_DATE: rd_word = date_q;
        SLOT_TIME: rd_word = time_q;
        default:   rd_word = bank_q[slot];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  // R3: writes to date/time raise their pending bits
  a_r3_date_pending: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_date |=> ctrl_q[PEND_DATE_BIT]);
  a_r3_time_pending: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_time |=> ctrl_q[PEND_TIME_BIT]);
  a_r3_ctrl_write_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr_ctrl && !bus_rd) |=> (ctrl_q[8:7] == $past(ctrl_q[8:7])));
  // R4: reading control returns the pending bits, then clears them
  a_r4_read_shows_pending: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_ctrl |=> (bus_rdata[8:7] == $past(ctrl_q[8:7])));
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_ctrl && !evt_wr_date && !evt_wr_time) |=> (ctrl_q[8:7] == 2'b00));
  // R5: unmapped or misaligned reads return zero
  a_r5_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == 32'd0));
  a_r5_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[1:0] != 2'b00) |=> (bus_rdata == 32'd0));
  // R7: read data holds without a read strobe
  a_r7_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R8: seconds count up and wrap
  a_r8_sec_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !evt_wr_time && !evt_sec_wrap) |=> (time_q[5:0] == $past(time_q[5:0]) + 6'd1));
  a_r8_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !evt_wr_time && evt_sec_wrap) |=> (time_q[5:0] == 6'd0));
  // R9: midnight clears hour, minute and second
  a_r9_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !evt_wr_time && evt_midnight) |=>
      (time_q[20:16] == 5'd0 && time_q[13:8] == 6'd0 && time_q[5:0] == 6'd0));
  // R11: a bus write beats a tick for the written word
  a_r11_time_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_time |=> (time_q == $past(bus_wdata)));
  a_r11_date_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_date |=> (date_q == $past(bus_wdata)));
  // R12: no tick, no write -> time and date stay put
  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !evt_wr_time && !evt_wr_date) |=> ($stable(time_q) && $stable(date_q)));
endmodule

// File: tb/rtc_calendar_regs_tb.sv
`timescale 1ns/1ps
module rtc_calendar_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        sec_tick = 1'b0;
  logic [31:0] rdata_b, rdata_a;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar_regs #(.MAP_SEL(1'b1), .AW(10), .BASE_YEAR(2000)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .sec_tick(sec_tick));

  rtc_calendar_regs #(.MAP_SEL(1'b0), .AW(10), .BASE_YEAR(2000)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .sec_tick(sec_tick));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 10'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] ra, output logic [31:0] rb);
    @(negedge clk);
    bus_addr = 10'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    ra = rdata_a; rb = rdata_b;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    sec_tick = 1'b1;
    repeat (n) @(negedge clk);
    sec_tick = 1'b0;
  endtask

  function automatic logic [31:0] mk_time(input int dow, input int h, input int m, input int s);
    return (32'(dow) << 29) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] mk_date(input int y, input int m, input int d);
    return (32'(y) << 16) | (32'(m) << 8) | 32'(d);
  endfunction

  function automatic int month_len(input int yoff, input int m);
    int y;
    y = 2000 + yoff;
    if (m == 2) return ((y % 400 == 0) || (y % 4 == 0 && y % 100 != 0)) ? 29 : 28;
    return 30 + ((m + m / 8) % 2);
  endfunction

  function automatic bit mapped_a(input int off);
    return (off <= 'h2C) || (off == 'h3C);
  endfunction

  function automatic bit mapped_b(input int off);
    return (off == 0) || (off == 4) || (off == 8) || (off == 'h10) || (off == 'h14) ||
           (off >= 'h20 && off <= 'h30) || (off >= 'h40 && off <= 'h50) || (off == 'h60) ||
           (off >= 'h100 && off <= 'h11C) || (off == 'h170) || (off == 'h180) ||
           (off == 'h190) || (off == 'h1F0);
  endfunction

  function automatic logic [31:0] pat(input int a);
    return 32'h5A00_0000 | (32'(a) << 10);
  endfunction

  task automatic set_clock(input logic [31:0] d, input logic [31:0] t);
    bus_write('h04, d); bus_write('h08, t);
    bus_write('h10, d); bus_write('h14, t);
  endtask

  task automatic get_clock(output logic [31:0] da, output logic [31:0] ta,
                           output logic [31:0] db, output logic [31:0] tb);
    logic [31:0] x, y;
    bus_read('h04, da, x);
    bus_read('h08, ta, x);
    bus_read('h10, y, db);
    bus_read('h14, y, tb);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] ra, rb, da, ta, db, tb, ea, eb;
    int prev;
    int targets [7] = '{1, 59, 60, 61, 3599, 3600, 3661};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 rdata after reset (B)", rdata_b, 32'd0);
    check("R1 rdata after reset (A)", rdata_a, 32'd0);
    foreach (targets[i]) begin
      int offs [7] = '{0, 4, 8, 'h10, 'h14, 'h20, 'h100};
      bus_read(offs[i], ra, rb);
      check("R1 word zero (A)", ra, 32'd0);
      check("R1 word zero (B)", rb, 32'd0);
    end

    // R3/R4: pending bits; control write masks bits 7 and 8
    bus_write(0, 32'hFFFF_FFFF);
    bus_read(0, ra, rb);
    check("R3 ctrl write keeps pending clear (A)", ra, 32'hFFFF_FE7F);
    check("R3 ctrl write keeps pending clear (B)", rb, 32'hFFFF_FE7F);
    bus_write('h04, 32'h0018_0310);  // date for A, plain for B
    bus_read(0, ra, rb);
    check("R3 date pending (A)", ra, 32'hFFFF_FEFF);
    check("R3 no pending from plain write (B)", rb, 32'hFFFF_FE7F);
    bus_read(0, ra, rb);
    check("R4 pending cleared by read (A)", ra, 32'hFFFF_FE7F);
    bus_write('h14, 32'h0001_0203);  // time for B, plain for A
    bus_write('h10, 32'h0018_0101);  // date for B
    bus_read(0, ra, rb);
    check("R3 time and date pending (B)", rb, 32'hFFFF_FFFF);
    check("R3 no pending from plain writes (A)", ra, 32'hFFFF_FE7F);
    bus_read(0, ra, rb);
    check("R4 second read clear (B)", rb, 32'hFFFF_FE7F);

    // R2/R5/R6: sweep every word offset of the window
    for (int a = 0; a < 256; a++) bus_write(a * 4, pat(a));
    bus_read(0, ra, rb);
    check("R4 ctrl after sweep (A)", ra, 32'h5A00_0180);
    check("R4 ctrl after sweep (B)", rb, 32'h5A00_0180);
    for (int a = 0; a < 256; a++) begin
      int off;
      off = a * 4;
      bus_read(off, ra, rb);
      ea = mapped_a(off) ? pat(a) : 32'd0;
      eb = mapped_b(off) ? pat(a) : 32'd0;
      check(mapped_a(off) ? "R6 plain storage (A)" : "R5 unmapped reads zero (A)", ra, ea);
      check(mapped_b(off) ? "R2 R6 map and storage (B)" : "R5 unmapped reads zero (B)", rb, eb);
    end

    // R5: misaligned accesses
    bus_write('h21, 32'hDEAD_BEEF);
    bus_read('h20, ra, rb);
    check("R5 misaligned write ignored (A)", ra, pat(8));
    check("R5 misaligned write ignored (B)", rb, pat(8));
    bus_read('h102, ra, rb);
    check("R5 misaligned read zero (B)", rb, 32'd0);

    // R7: read data holds through idle cycles and writes
    bus_read('h100, ra, rb);
    bus_write('h104, 32'h1234_5678);
    repeat (3) @(negedge clk);
    check("R7 rdata held (B)", rdata_b, pat(64));
    check("R7 rdata held (A)", rdata_a, 32'd0);

    // R8/R12: second, minute and hour carries
    set_clock(mk_date(24, 1, 1), mk_time(0, 0, 0, 0));
    prev = 0;
    foreach (targets[i]) begin
      int t;
      t = targets[i];
      ticks(t - prev);
      prev = t;
      get_clock(da, ta, db, tb);
      ea = mk_time(0, t / 3600, (t / 60) % 60, t % 60);
      check("R8 R12 time after ticks (A)", ta, ea);
      check("R8 R12 time after ticks (B)", tb, ea);
      check("R12 date untouched (B)", db, mk_date(24, 1, 1));
    end

    // R9/R10: midnight at each month end across leap and non-leap years
    foreach (targets[k]) begin
      int yoffs [4] = '{23, 24, 0, 100};
      if (k < 4) begin
        for (int m = 1; m <= 12; m++) begin
          int y;
          y = yoffs[k];
          set_clock(mk_date(y, m, month_len(y, m)), mk_time(m % 7, 23, 59, 59));
          ticks(1);
          get_clock(da, ta, db, tb);
          ea = (m == 12) ? mk_date(y + 1, 1, 1) : mk_date(y, m + 1, 1);
          check("R10 month end (A)", da, ea);
          check("R10 month end (B)", db, ea);
          check("R9 midnight weekday (B)", tb, mk_time((m % 7 + 1) % 7, 0, 0, 0));
        end
      end
    end
    set_clock(mk_date(24, 2, 28), mk_time(6, 23, 59, 59));
    ticks(1);
    get_clock(da, ta, db, tb);
    check("R10 leap Feb 29 (B)", db, mk_date(24, 2, 29));
    check("R9 Sunday wraps to Monday (A)", ta, mk_time(0, 0, 0, 0));
    set_clock(mk_date(0, 2, 28), mk_time(1, 23, 59, 59));
    ticks(1);
    get_clock(da, ta, db, tb);
    check("R10 year 2000 leap (A)", da, mk_date(0, 2, 29));

    // R11: write with tick in the same cycle
    set_clock(mk_date(24, 3, 15), mk_time(2, 10, 20, 30));
    @(negedge clk);
    bus_addr = 10'h014; bus_wdata = mk_time(4, 5, 6, 7); bus_wr = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sec_tick = 1'b0;
    get_clock(da, ta, db, tb);
    check("R11 time write wins (B)", tb, mk_time(4, 5, 6, 7));
    check("R11 other layout ticks (A)", ta, mk_time(2, 10, 20, 31));
    set_clock(mk_date(24, 3, 15), mk_time(2, 23, 59, 59));
    @(negedge clk);
    bus_addr = 10'h004; bus_wdata = mk_date(30, 7, 4); bus_wr = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sec_tick = 1'b0;
    get_clock(da, ta, db, tb);
    check("R11 date write wins (A)", da, mk_date(30, 7, 4));
    check("R11 time still ticks (A)", ta, mk_time(3, 0, 0, 0));
    check("R11 unwritten date ticks (B)", db, mk_date(24, 3, 16));

    finish_run();
  end
endmodule